// File: doc/BRIEF.md
# Task-Level Out-of-Order Dispatch Scheduler

This block schedules coarse-grained tasks the way a dynamically scheduled core schedules instructions. A host pushes tasks in program order. Each task has a type code, one output parameter and zero to two input parameters. The scheduler keeps a table that records, for every parameter, whether its newest value exists yet or which in-flight task will produce it. Because every new writer takes over the table entry for its output, write-after-write and write-after-read conflicts disappear. Only true read-after-write dependencies make a task wait.

Tasks wait in eight reservation slots until both inputs are available. Each task type is served by exactly one dedicated functional unit, so a busy unit holds back only tasks of its own type. Units report completion over a single shared bus that carries the slot tag. That broadcast wakes waiting consumers, releases the unit and clears the table entry if it still names that tag. Completed tasks then leave in program order through a reorder pointer, one per cycle.

The issue port is valid/ready. A task is taken on every cycle where both are high. While `issue_ready` is low the host must hold its task. The fields on the issue port are ignored while `issue_valid` is low. The dispatch, completion and retirement pins are plain single-cycle strobes with no back-pressure. The environment must report each dispatched tag exactly once, and it may report at most one completion per cycle.

Top module: `task_dispatch_sched`

## Requirements
- R1: `issue_ready` is high exactly when fewer than 8 slots are occupied. A task is accepted on any cycle with `issue_valid` and `issue_ready` both high. Slot tags are handed out as 0,1,…,7,0,… in acceptance order.
- R2: A task never dispatches before the completion of the producer of any of its inputs has appeared on the completion bus. The earliest it can dispatch is the cycle after that completion.
- R3: A later task writing the same output parameter as an earlier task may dispatch and complete before the earlier one completes.
- R4: A later task that overwrites a parameter does not make an earlier, still-waiting reader of that parameter wait for the later task. The reader waits only for the producer that was current when the reader was accepted.
- R5: Type code t dispatches only to unit t, on `disp_valid[t]` with its tag in `disp_tag[3t+2:3t]`. A unit takes at most one task per cycle. It accepts no further task from its dispatch cycle until its tag has appeared on the completion bus.
- R6: Among ready, undispatched tasks of one type, the unit receives the one accepted earliest.
- R7: A completion wakes every waiting input that names its tag. A task accepted in the same cycle as its producer's completion sees that input as ready.
- R8: The own port reports, for the parameter on `own_idx`, either ready or the tag of its newest uncompleted writer. A completion clears the entry only if the entry still holds that tag.
- R9: `ret_valid` pulses for one cycle per task, in acceptance order, on the cycle after the oldest occupied slot has completed, and gives that slot's tag and output parameter. Retirement frees the slot.
- R10: After reset, `issue_ready` is high, no dispatch or retirement is signalled, and every parameter reads ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Task offered |
| issue_ready | output | 1 | A slot is free |
| issue_type | input | 2 | Task type, equal to its unit index |
| issue_dst | input | 4 | Output parameter id |
| issue_src0_en | input | 1 | First input present |
| issue_src0 | input | 4 | First input parameter id |
| issue_src1_en | input | 1 | Second input present |
| issue_src1 | input | 4 | Second input parameter id |
| disp_valid | output | 4 | Per-unit dispatch strobe |
| disp_tag | output | 12 | Per-unit dispatched slot tag, 3 bits per unit |
| cmp_valid | input | 1 | Completion broadcast valid |
| cmp_tag | input | 3 | Tag of the completed slot |
| ret_valid | output | 1 | Retirement strobe |
| ret_tag | output | 3 | Retired slot tag |
| ret_dst | output | 4 | Output parameter of the retired task |
| own_idx | input | 4 | Parameter to inspect |
| own_ready | output | 1 | Inspected parameter has no pending writer |
| own_tag | output | 3 | Pending writer's tag when not ready |

## Verification
The hardest state to reach is a write-after-read overlap. It needs a reader still parked on a slow producer while a younger, faster task renames the same parameter and completes. Only then can the bench tell whether the reader wrongly adopted the new owner. The bench reaches it by giving each unit its own programmable latency: the first writer gets a long one, the overwriting task a short one, and the reader sits between them. The same latency skew lets a later writer of a shared output finish first. It also fills all eight slots behind one slow unit, so that acceptance stalls and completions collide with new issues.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int unsigned DEF_SLOTS  = 8;
  localparam int unsigned DEF_PARAMS = 16;
  localparam int unsigned DEF_UNITS  = 4;
endpackage

// File: rtl/ts_status_table.sv
// Parameter ownership table: ready bit plus producing slot tag per parameter.
module ts_status_table #(
  parameter  int unsigned NP = 16,
  parameter  int unsigned NS = 8,
  localparam int unsigned PW = $clog2(NP),
  localparam int unsigned SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [SW-1:0] wr_tag,
  input  logic          cmp_valid,
  input  logic [SW-1:0] cmp_tag,
  input  logic [PW-1:0] ra_idx,
  output logic          ra_rdy,
  output logic [SW-1:0] ra_tag,
  input  logic [PW-1:0] rb_idx,
  output logic          rb_rdy,
  output logic [SW-1:0] rb_tag,
  input  logic [PW-1:0] q_idx,
  output logic          q_rdy,
  output logic [SW-1:0] q_tag
);
  logic [NP-1:0] rdy_q;
  logic [SW-1:0] tag_q [NP];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= '1;
      for (int i = 0; i < NP; i++) tag_q[i] <= '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (wr_en && wr_idx == PW'(i)) begin
          rdy_q[i] <= 1'b0;
          tag_q[i] <= wr_tag;
        end else if (cmp_valid && !rdy_q[i] && tag_q[i] == cmp_tag) begin
          rdy_q[i] <= 1'b1;
        end
      end
    end
  end

  // same-cycle completion is forwarded to the issuing task
  assign ra_rdy = rdy_q[ra_idx] || (cmp_valid && tag_q[ra_idx] == cmp_tag);
  assign ra_tag = tag_q[ra_idx];
  assign rb_rdy = rdy_q[rb_idx] || (cmp_valid && tag_q[rb_idx] == cmp_tag);
  assign rb_tag = tag_q[rb_idx];
  assign q_rdy  = rdy_q[q_idx];
  assign q_tag  = tag_q[q_idx];

  // R8: a new writer takes ownership of its output entry
  a_r8_write_owns: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!rdy_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/ts_age_picker.sv
// Finds the first requesting slot walking forward from the oldest one.
module ts_age_picker #(
  parameter  int unsigned NS = 8,
  localparam int unsigned SW = $clog2(NS)
) (
  input  logic [SW-1:0] head,
  input  logic [NS-1:0] req,
  output logic          found,
  output logic [SW-1:0] pick
);
  logic [SW-1:0] idx;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    idx   = head;
    for (int k = 0; k < NS; k++) begin
      idx = head + SW'(k);
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = idx;
      end
    end
  end
endmodule

// File: rtl/ts_slot_bank.sv
// Reservation slots allocated and retired as a circular order buffer.
module ts_slot_bank #(
  parameter  int unsigned NS = 8,
  parameter  int unsigned NP = 16,
  parameter  int unsigned NU = 4,
  localparam int unsigned SW = $clog2(NS),
  localparam int unsigned PW = $clog2(NP),
  localparam int unsigned TW = (NU > 1) ? $clog2(NU) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc,
  input  logic [TW-1:0]  a_type,
  input  logic [PW-1:0]  a_dst,
  input  logic           a_rdy0,
  input  logic [SW-1:0]  a_tag0,
  input  logic           a_rdy1,
  input  logic [SW-1:0]  a_tag1,
  input  logic           cmp_valid,
  input  logic [SW-1:0]  cmp_tag,
  input  logic [NS-1:0]  disp_mark,
  output logic           full,
  output logic [SW-1:0]  tail,
  output logic [SW-1:0]  head,
  output logic [NS-1:0]  cand,
  output logic [NS*TW-1:0] type_flat,
  output logic           ret_valid,
  output logic [SW-1:0]  ret_tag,
  output logic [PW-1:0]  ret_dst
);
  logic [NS-1:0] valid_q, done_q, disp_q, rdy0_q, rdy1_q;
  logic [SW-1:0] tag0_q [NS];
  logic [SW-1:0] tag1_q [NS];
  logic [TW-1:0] type_q [NS];
  logic [PW-1:0] dst_q  [NS];
  logic [SW-1:0] head_q, tail_q;
  logic [SW:0]   count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      done_q  <= '0;
      disp_q  <= '0;
      rdy0_q  <= '0;
      rdy1_q  <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      for (int s = 0; s < NS; s++) begin
        tag0_q[s] <= '0;
        tag1_q[s] <= '0;
        type_q[s] <= '0;
        dst_q[s]  <= '0;
      end
    end else begin
      for (int s = 0; s < NS; s++) begin
        if (cmp_valid && valid_q[s]) begin
          if (!rdy0_q[s] && tag0_q[s] == cmp_tag) rdy0_q[s] <= 1'b1;
          if (!rdy1_q[s] && tag1_q[s] == cmp_tag) rdy1_q[s] <= 1'b1;
          if (SW'(s) == cmp_tag) done_q[s] <= 1'b1;
        end
        if (disp_mark[s]) disp_q[s] <= 1'b1;
      end
      if (ret_valid) begin
        valid_q[head_q] <= 1'b0;
        head_q          <= head_q + SW'(1);
      end
      if (alloc) begin
        valid_q[tail_q] <= 1'b1;
        done_q[tail_q]  <= 1'b0;
        disp_q[tail_q]  <= 1'b0;
        type_q[tail_q]  <= a_type;
        dst_q[tail_q]   <= a_dst;
        rdy0_q[tail_q]  <= a_rdy0;
        tag0_q[tail_q]  <= a_tag0;
        rdy1_q[tail_q]  <= a_rdy1;
        tag1_q[tail_q]  <= a_tag1;
        tail_q          <= tail_q + SW'(1);
      end
      count_q <= count_q + {{SW{1'b0}}, alloc} - {{SW{1'b0}}, ret_valid};
    end
  end

  assign full      = (count_q == (SW+1)'(NS));
  assign tail      = tail_q;
  assign head      = head_q;
  assign cand      = valid_q & ~disp_q & rdy0_q & rdy1_q;
  assign ret_valid = valid_q[head_q] && done_q[head_q];
  assign ret_tag   = head_q;
  assign ret_dst   = dst_q[head_q];

  for (genvar s = 0; s < NS; s++) begin : g_type
    assign type_flat[s*TW +: TW] = type_q[s];
    // R2: only a slot with both inputs available is ever dispatched
    a_r2_mark_ready: assert property (@(posedge clk) disable iff (!rst_n)
      disp_mark[s] |-> cand[s]);
  end

  // R1: allocation never overwrites an occupied slot
  a_r1_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !valid_q[tail_q]);
  // R7: a completion names a live, dispatched, not yet completed slot
  a_r7_cmp_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> (valid_q[cmp_tag] && disp_q[cmp_tag] && !done_q[cmp_tag]));
  // R9: each retirement advances the reorder pointer by one
  a_r9_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> (head_q == $past(head_q) + SW'(1)));
endmodule

// File: rtl/task_dispatch_sched.sv
module task_dispatch_sched
  import ts_pkg::*;
#(
  parameter  int unsigned NUM_SLOTS  = DEF_SLOTS,
  parameter  int unsigned NUM_PARAMS = DEF_PARAMS,
  parameter  int unsigned NUM_UNITS  = DEF_UNITS,
  localparam int unsigned SW = $clog2(NUM_SLOTS),
  localparam int unsigned PW = $clog2(NUM_PARAMS),
  localparam int unsigned TW = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   issue_valid,
  output logic                   issue_ready,
  input  logic [TW-1:0]          issue_type,
  input  logic [PW-1:0]          issue_dst,
  input  logic                   issue_src0_en,
  input  logic [PW-1:0]          issue_src0,
  input  logic                   issue_src1_en,
  input  logic [PW-1:0]          issue_src1,
  output logic [NUM_UNITS-1:0]   disp_valid,
  output logic [NUM_UNITS*SW-1:0] disp_tag,
  input  logic                   cmp_valid,
  input  logic [SW-1:0]          cmp_tag,
  output logic                   ret_valid,
  output logic [SW-1:0]          ret_tag,
  output logic [PW-1:0]          ret_dst,
  input  logic [PW-1:0]          own_idx,
  output logic                   own_ready,
  output logic [SW-1:0]          own_tag
);
  logic                      alloc, full;
  logic [SW-1:0]             head, tail;
  logic [NUM_SLOTS-1:0]      cand, disp_mark;
  logic [NUM_SLOTS*TW-1:0]   type_flat;
  logic                      ra_rdy, rb_rdy;
  logic [SW-1:0]             ra_tag, rb_tag;
  logic [SW-1:0]             pick_w [NUM_UNITS];

  assign issue_ready = !full;
  assign alloc       = issue_valid && !full;

  ts_status_table #(.NP(NUM_PARAMS), .NS(NUM_SLOTS)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .wr_en(alloc), .wr_idx(issue_dst), .wr_tag(tail),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .ra_idx(issue_src0), .ra_rdy(ra_rdy), .ra_tag(ra_tag),
    .rb_idx(issue_src1), .rb_rdy(rb_rdy), .rb_tag(rb_tag),
    .q_idx(own_idx), .q_rdy(own_ready), .q_tag(own_tag)
  );

  ts_slot_bank #(.NS(NUM_SLOTS), .NP(NUM_PARAMS), .NU(NUM_UNITS)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .alloc(alloc), .a_type(issue_type), .a_dst(issue_dst),
    .a_rdy0(!issue_src0_en || ra_rdy), .a_tag0(ra_tag),
    .a_rdy1(!issue_src1_en || rb_rdy), .a_tag1(rb_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .disp_mark(disp_mark),
    .full(full), .tail(tail), .head(head),
    .cand(cand), .type_flat(type_flat),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_dst(ret_dst)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [NUM_SLOTS-1:0] req;
    logic                 found;
    logic [SW-1:0]        pick;
    logic                 busy_q;
    logic [SW-1:0]        btag_q;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_req
      assign req[s] = cand[s] && (type_flat[s*TW +: TW] == TW'(u));
    end

    ts_age_picker #(.NS(NUM_SLOTS)) u_pick (
      .head(head), .req(req), .found(found), .pick(pick)
    );

    assign disp_valid[u]         = found && !busy_q;
    assign disp_tag[u*SW +: SW]  = pick;
    assign pick_w[u]             = pick;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        btag_q <= '0;
      end else if (disp_valid[u]) begin
        busy_q <= 1'b1;
        btag_q <= pick;
      end else if (cmp_valid && busy_q && btag_q == cmp_tag) begin
        busy_q <= 1'b0;
      end
    end

    // R5: a unit that just took a task is held busy on the next cycle
    a_r5_unit_hold: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid[u] |=> !disp_valid[u]);
  end

  always_comb begin
    disp_mark = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      if (disp_valid[u]) disp_mark[pick_w[u]] = 1'b1;
  end
endmodule

// File: tb/sim_task_dispatch_sched.sv
`timescale 1ns/1ps
module sim_task_dispatch_sched;
  localparam int NS = 8, NP = 16, NU = 4, SW = 3, PW = 4, TW = 2, MAXT = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic issue_valid, issue_ready, issue_src0_en, issue_src1_en;
  logic [TW-1:0] issue_type;
  logic [PW-1:0] issue_dst, issue_src0, issue_src1, own_idx, ret_dst;
  logic [NU-1:0] disp_valid;
  logic [NU*SW-1:0] disp_tag;
  logic cmp_valid, ret_valid, own_ready;
  logic [SW-1:0] cmp_tag, ret_tag, own_tag;

  task_dispatch_sched u0 (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_type(issue_type),
    .issue_dst(issue_dst), .issue_src0_en(issue_src0_en), .issue_src0(issue_src0),
    .issue_src1_en(issue_src1_en), .issue_src1(issue_src1),
    .disp_valid(disp_valid), .disp_tag(disp_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_dst(ret_dst),
    .own_idx(own_idx), .own_ready(own_ready), .own_tag(own_tag)
  );

  // program and reference state
  int t_type[MAXT], t_dst[MAXT], t_e0[MAXT], t_s0[MAXT], t_e1[MAXT], t_s1[MAXT];
  int t_p0[MAXT], t_p1[MAXT], t_dispc[MAXT], t_donec[MAXT];
  bit t_disp[MAXT], t_done[MAXT];
  int last_wr[NP];
  bit u_busy[NU];
  int u_timer[NU], u_task[NU], lat[NU];
  int cq[$];
  int n_prog, n_iss, n_ret, cyc, n_chk, n_err, dens, stall_seen;
  bit dog;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  function automatic bit t_ready(input int i);
    return (t_p0[i] < 0 || t_done[t_p0[i]]) && (t_p1[i] < 0 || t_done[t_p1[i]]);
  endfunction

  task automatic add(input int ty, input int dst, input int e0, input int s0,
                     input int e1, input int s1);
    t_type[n_prog] = ty; t_dst[n_prog] = dst;
    t_e0[n_prog] = e0; t_s0[n_prog] = s0; t_e1[n_prog] = e1; t_s1[n_prog] = s1;
    t_disp[n_prog] = 0; t_done[n_prog] = 0;
    t_dispc[n_prog] = -1; t_donec[n_prog] = -1;
    n_prog++;
  endtask

  // one clock: compare at the falling edge, drive, advance the model
  task automatic step();
    int exp_pick[NU];
    bit exp_v[NU];
    bit exp_rdy, exp_ret, fire, cv;
    int ct, owner, q;
    exp_rdy = (n_iss - n_ret) < NS;
    chk(issue_ready === exp_rdy, "R1 issue_ready", issue_ready, exp_rdy);
    if (!issue_ready) stall_seen++;
    exp_ret = (n_ret < n_iss) && t_done[n_ret];
    chk(ret_valid === exp_ret, "R9 ret_valid", ret_valid, exp_ret);
    if (exp_ret) begin
      chk(ret_tag == SW'(n_ret % NS), "R9 ret_tag", ret_tag, n_ret % NS);
      chk(ret_dst == PW'(t_dst[n_ret]), "R9 ret_dst", ret_dst, t_dst[n_ret]);
    end
    for (int u = 0; u < NU; u++) begin
      exp_pick[u] = -1;
      for (int i = n_ret; i < n_iss; i++)
        if (exp_pick[u] < 0 && !t_disp[i] && t_type[i] == u && t_ready(i)) exp_pick[u] = i;
      exp_v[u] = (exp_pick[u] >= 0) && !u_busy[u];
      chk(disp_valid[u] === exp_v[u], "R5 R2 dispatch strobe", disp_valid[u], exp_v[u]);
      if (exp_v[u])
        chk(disp_tag[u*SW +: SW] == SW'(exp_pick[u] % NS), "R6 R7 dispatch tag",
            disp_tag[u*SW +: SW], exp_pick[u] % NS);
    end
    q = own_idx;
    owner = last_wr[q];
    chk(own_ready === (owner < 0 || t_done[owner]), "R8 own_ready", own_ready,
        (owner < 0 || t_done[owner]));
    if (!(owner < 0 || t_done[owner]))
      chk(own_tag == SW'(owner % NS), "R8 own_tag", own_tag, owner % NS);

    cv = 0; ct = 0;
    if (cq.size() > 0) begin ct = cq.pop_front(); cv = 1; end
    cmp_valid = cv;
    cmp_tag   = cv ? SW'(ct % NS) : SW'($urandom % NS);
    fire = 0;
    if (n_iss < n_prog && ($urandom % 4) < dens) begin
      issue_valid   = 1'b1;
      issue_type    = TW'(t_type[n_iss]);
      issue_dst     = PW'(t_dst[n_iss]);
      issue_src0_en = t_e0[n_iss] != 0;
      issue_src0    = PW'(t_s0[n_iss]);
      issue_src1_en = t_e1[n_iss] != 0;
      issue_src1    = PW'(t_s1[n_iss]);
      fire = exp_rdy;
    end else begin
      issue_valid   = 1'b0;
      issue_type    = TW'($urandom);
      issue_dst     = PW'($urandom);
      issue_src0_en = 1'($urandom);
      issue_src0    = PW'($urandom);
      issue_src1_en = 1'($urandom);
      issue_src1    = PW'($urandom);
    end
    own_idx = PW'(cyc % NP);

    if (cv) begin
      t_done[ct] = 1; t_donec[ct] = cyc; u_busy[t_type[ct]] = 0;
    end
    if (exp_ret) n_ret++;
    for (int u = 0; u < NU; u++)
      if (u_busy[u] && u_timer[u] > 0) begin
        u_timer[u]--;
        if (u_timer[u] == 0) cq.push_back(u_task[u]);
      end
    for (int u = 0; u < NU; u++)
      if (exp_v[u]) begin
        t_disp[exp_pick[u]] = 1; t_dispc[exp_pick[u]] = cyc;
        u_busy[u] = 1; u_task[u] = exp_pick[u]; u_timer[u] = lat[u];
      end
    if (fire) begin
      t_p0[n_iss] = t_e0[n_iss] != 0 ? last_wr[t_s0[n_iss]] : -1;
      t_p1[n_iss] = t_e1[n_iss] != 0 ? last_wr[t_s1[n_iss]] : -1;
      last_wr[t_dst[n_iss]] = n_iss;
      n_iss++;
    end
    cyc++;
    @(posedge clk);
    @(negedge clk);
    if (cyc > 150000) dog = 1;
  endtask

  task automatic run_phase();
    while (!dog && (n_iss < n_prog || n_ret < n_iss)) step();
    for (int k = 0; k < 4 && !dog; k++) step();
  endtask

  task automatic check_all_ready(input string rq);
    for (int p = 0; p < NP; p++) begin
      own_idx = PW'(p);
      #1;
      chk(own_ready === 1'b1, rq, own_ready, 1);
    end
    own_idx = PW'(cyc % NP);
    #1;
  endtask

  initial begin
    int a, b, c, w, r;
    n_prog = 0; n_iss = 0; n_ret = 0; cyc = 0; n_chk = 0; n_err = 0;
    stall_seen = 0; dog = 0; dens = 4;
    for (int p = 0; p < NP; p++) last_wr[p] = -1;
    for (int u = 0; u < NU; u++) begin u_busy[u] = 0; u_timer[u] = 0; lat[u] = 2; end
    issue_valid = 0; issue_type = '0; issue_dst = '0; issue_src0_en = 0; issue_src0 = '0;
    issue_src1_en = 0; issue_src1 = '0; cmp_valid = 0; cmp_tag = '0; own_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: reset state
    chk(issue_ready === 1'b1, "R10 issue_ready", issue_ready, 1);
    chk(disp_valid === '0, "R10 disp_valid", disp_valid, 0);
    chk(ret_valid === 1'b0, "R10 ret_valid", ret_valid, 0);
    check_all_ready("R10 own_ready");

    // R2: read-after-write chain across three units
    lat = '{3, 3, 3, 3};
    a = n_prog; add(0, 1, 1, 2, 0, 0);
    b = n_prog; add(1, 3, 1, 1, 0, 0);
    c = n_prog; add(2, 4, 1, 3, 1, 1);
    run_phase();
    chk(t_dispc[b] > t_donec[a], "R2 consumer after producer", t_dispc[b], t_donec[a] + 1);
    chk(t_dispc[c] > t_donec[b], "R2 second link", t_dispc[c], t_donec[b] + 1);

    // R3: later writer of the same output finishes first
    lat = '{20, 1, 2, 2};
    a = n_prog; add(0, 5, 0, 0, 0, 0);
    b = n_prog; add(1, 5, 0, 0, 0, 0);
    run_phase();
    chk(t_donec[b] < t_donec[a], "R3 later writer completes first", t_donec[b], t_donec[a]);
    check_all_ready("R8 entry cleared after drain");

    // R4: overwrite while an earlier reader still waits
    lat = '{15, 1, 1, 2};
    a = n_prog; add(0, 7, 0, 0, 0, 0);
    r = n_prog; add(2, 8, 1, 7, 0, 0);
    w = n_prog; add(1, 7, 0, 0, 0, 0);
    run_phase();
    chk(t_donec[w] < t_dispc[r], "R4 overwriter done before reader", t_donec[w], t_dispc[r]);
    chk(t_dispc[r] > t_donec[a], "R4 reader waits on original producer", t_dispc[r], t_donec[a] + 1);

    // R5/R6: structural hazard and oldest-first arbitration
    lat = '{10, 1, 4, 4};
    a = n_prog; add(0, 9, 0, 0, 0, 0);
    b = n_prog; add(3, 10, 1, 9, 0, 0);
    c = n_prog; add(3, 11, 1, 9, 0, 0);
    for (int k = 0; k < 3; k++) add(3, 12 + k, 0, 0, 0, 0);
    w = n_prog; add(1, 2, 0, 0, 0, 0);
    run_phase();
    chk(t_dispc[b] < t_dispc[c], "R6 older ready task first", t_dispc[b], t_dispc[c]);
    chk(t_dispc[w] < t_dispc[b], "R5 other unit not held by busy unit", t_dispc[w], t_dispc[b]);
    chk(t_dispc[c] - t_dispc[b] >= 4, "R5 unit busy until completion", t_dispc[c] - t_dispc[b], 4);

    // R1: fill all slots behind one slow unit
    lat = '{30, 1, 1, 1};
    stall_seen = 0;
    for (int k = 0; k < 12; k++) add(0, k, 0, 0, 0, 0);
    run_phase();
    chk(stall_seen > 0, "R1 issue stalls when full", stall_seen, 1);

    // R7/R9: random traffic with colliding completions and issues
    for (int ph = 0; ph < 2; ph++) begin
      for (int u = 0; u < NU; u++) lat[u] = 1 + ($urandom % 5);
      dens = 2 + ph;
      for (int k = 0; k < 300; k++)
        add($urandom % NU, $urandom % NP, $urandom % 2, $urandom % NP,
            $urandom % 2, $urandom % NP);
      run_phase();
    end
    chk(n_ret == n_prog, "R9 all tasks retired", n_ret, n_prog);
    check_all_ready("R8 final ownership");

    if (dog) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule